// File: doc/BRIEF.md
# Strobed Control-Word Load Sequencer

This block drives a 16-bit parallel control port whose receiver latches a value on a strobe bit carried inside the word itself. A single start pulse makes it play a fixed script of seven strobed transfers that load a remote instruction register. The first three transfers carry a caller-supplied control word. The middle one of those three also carries two extra flags that tell the remote side to stop and to clear its register. The last four transfers carry four consecutive data words, which the block fetches from a small memory starting at a caller-supplied base address. They are sent as register slices 0, 1, 2 and 3, in that order.

Every transfer consists of three port levels: the word with the strobe bit low, then with it high, then low again. Each level is held for a parameterised number of cycles. Before each data transfer the block issues a one-cycle memory read and takes the returned word one cycle later. After the last transfer it raises a one-cycle done pulse and returns to idle. While idle it keeps the last word on the port with the strobe bit low. The block does not interpret the loaded words.

Top module: `ctl_load_seq`

## Requirements
- R1: While reset is held low at a clock edge, the next cycle shows port_o = 0x0000, rd_req_o = 0 and done_o = 0.
- R2: Each transfer presents its word on port_o as three levels of HOLD_CYC cycles each (default 2): strobe bit 6 (0x0040) low, then high, then low. Bit 6 is high at no other time.
- R3: The seven transfers follow a fixed order: the control word C; then C | 0x4000 | 0x0400 (stop flag at bit 14, clear flag at bit 10); then C; then the memory words at base+0, base+1, base+2 and base+3.
- R4: Only bit 6 of a transferred word is overridden, being forced by the level. Every other bit of each data word passes unchanged, and the two flags of R3 never appear in the data transfers unless the memory word holds them.
- R5: Before each data transfer, rd_req_o is high for exactly one cycle with rd_addr_o = base + k (k = 0..3, modulo 2^ADDR_W). The word on rd_data_i in the following cycle is captured, and its first level begins in the cycle after that.
- R6: done_o is high for exactly one cycle, the cycle right after the last level of the seventh transfer.
- R7: A start pulse seen while a sequence is running, including the done cycle, is ignored.
- R8: The control word and base address are captured only on an accepted start, so later changes on those inputs have no effect. Outside a transfer, port_o holds the most recent word with bit 6 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| ctl_word_i | input | 16 | Control word for the first three transfers |
| base_addr_i | input | ADDR_W (8) | Memory address of data word 0 |
| rd_data_i | input | 16 | Memory read data, valid one cycle after the request |
| port_o | output | 16 | Parallel control port value, strobe at bit 6 |
| rd_req_o | output | 1 | One-cycle memory read request |
| rd_addr_o | output | ADDR_W (8) | Memory read address, valid while rd_req_o is high |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The script is run with several control words: all zeros, a mixed value, one that already holds the two flags, and one with the strobe bit wrongly set. Together they separate the flag insertion in the second transfer from bits that were merely passed through, and they show that bit 6 of the input is overridden. The memory holds distinct words, some with bit 6 or the flag bits set, and one run uses a base address near the top of the address range. These runs tell the correct address order and wrap-around apart from a fixed or mis-incremented index, and show that data words are sent unmerged. Start pulses are also given in mid-sequence and in the done cycle, with new control and base values on the inputs, to show that a running sequence is neither restarted nor changed.

// File: rtl/ctl_load_pkg.sv
// Package: shared types and fixed script constants for the strobed
// control-word load sequencer.
package ctl_load_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XFER  = 3'd1,
        ST_FETCH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_t;

    // Fixed script shape: control transfers first, data transfers after
    localparam int CTRL_STEPS  = 3;
    localparam int DATA_STEPS  = 4;
    localparam int TOTAL_STEPS = CTRL_STEPS + DATA_STEPS;
    localparam int LAST_STEP   = TOTAL_STEPS - 1;
    localparam int STEP_W      = $clog2(TOTAL_STEPS);

    // Levels per transfer: low, high, low
    localparam int LEVELS      = 3;
    localparam int STROBE_LVL  = 1;
    localparam int LAST_LVL    = LEVELS - 1;

endpackage

// File: rtl/cls_step_ctrl.sv
// Module: cls_step_ctrl
// Walks the seven-step script. It tracks the step index, the level inside
// the current transfer and the hold count of that level, and it inserts a
// fetch/wait pair in front of every data step.
// Assumes: HOLD_CYC >= 1 and a memory read latency of one cycle.
module cls_step_ctrl
    import ctl_load_pkg::*;
#(
    parameter int HOLD_CYC = 2,
    localparam int HOLD_W  = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output seq_state_t        state_o,
    output logic [STEP_W-1:0] step_o,
    output logic [1:0]        level_o,
    output logic [HOLD_W-1:0] hold_o,
    output logic              accept_o,
    output logic              advance_o,
    output logic              fetch_o,
    output logic              capture_o,
    output logic              done_o
);

    seq_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic [1:0]        level_q;
    logic [HOLD_W-1:0] hold_q;
    logic              hold_end;
    logic              xfer_end;
    logic              on_last_step;

    // End-of-level and end-of-transfer detection
    assign hold_end     = (hold_q == HOLD_W'(HOLD_CYC - 1));
    assign xfer_end     = (state_q == ST_XFER) && hold_end && (level_q == 2'(LAST_LVL));
    assign on_last_step = (step_q == STEP_W'(LAST_STEP));

    // State, step, level and hold counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            level_q <= '0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_XFER;
                        step_q  <= '0;
                        level_q <= '0;
                        hold_q  <= '0;
                    end
                end
                ST_XFER: begin
                    if (!hold_end) begin
                        hold_q <= hold_q + 1'b1;
                    end else begin
                        hold_q <= '0;
                        if (level_q != 2'(LAST_LVL)) begin
                            level_q <= level_q + 1'b1;
                        end else begin
                            level_q <= '0;
                            if (on_last_step) begin
                                state_q <= ST_DONE;
                            end else begin
                                step_q  <= step_q + 1'b1;
                                state_q <= ((int'(step_q) + 1) >= CTRL_STEPS) ? ST_FETCH : ST_XFER;
                            end
                        end
                    end
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT:  state_q <= ST_XFER;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded strobes for the word path
    assign state_o   = state_q;
    assign step_o    = step_q;
    assign level_o   = level_q;
    assign hold_o    = hold_q;
    assign accept_o  = (state_q == ST_IDLE) && start_i;
    assign advance_o = xfer_end && !on_last_step;
    assign fetch_o   = (state_q == ST_FETCH);
    assign capture_o = (state_q == ST_WAIT);
    assign done_o    = (state_q == ST_DONE);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                               // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q == ST_XFER && on_last_step && level_q == 2'(LAST_LVL)));  // R6
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(step_q) <= LAST_STEP);                                        // R3
    AST_FETCH_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> (int'(step_q) >= CTRL_STEPS));                         // R5
    AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level_q) <= LAST_LVL);                                        // R2

endmodule

// File: rtl/cls_word_sel.sv
// Module: cls_word_sel
// Holds the captured control word and base address, and the word that is
// currently being transferred. It loads the next word at each step change
// and builds the memory address for each data step.
// Assumes: advance_i, capture_i and accept_i are never high together.
module cls_word_sel
    import ctl_load_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int ADDR_W       = 8,
    parameter int STOP_FLAG    = 14,
    parameter int CLEAR_FLAG   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              advance_i,
    input  logic              capture_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [WORD_W-1:0] ctl_word_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [WORD_W-1:0] word_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    localparam logic [WORD_W-1:0] FLAG_MASK =
        (WORD_W'(1) << STOP_FLAG) | (WORD_W'(1) << CLEAR_FLAG);

    logic [WORD_W-1:0] ctl_q;
    logic [ADDR_W-1:0] base_q;
    logic [WORD_W-1:0] word_q;
    logic [STEP_W-1:0] next_step;
    logic [STEP_W-1:0] data_idx;

    assign next_step = step_i + 1'b1;
    assign data_idx  = step_i - STEP_W'(CTRL_STEPS);

    // Capture of start arguments and selection of the word in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            base_q <= '0;
            word_q <= '0;
        end else if (accept_i) begin
            ctl_q  <= ctl_word_i;
            base_q <= base_addr_i;
            word_q <= ctl_word_i;
        end else if (advance_i) begin
            if (next_step == STEP_W'(1)) begin
                word_q <= ctl_q | FLAG_MASK;
            end else if (next_step == STEP_W'(2)) begin
                word_q <= ctl_q;
            end
        end else if (capture_i) begin
            word_q <= rd_data_i;
        end
    end

    // Memory address for the current data step
    assign rd_addr_o = base_q + ADDR_W'(data_idx);
    assign word_o    = word_q;

    AST_ARGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> ($stable(ctl_q) && $stable(base_q)));                // R8
    AST_FLAGS_ON_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && step_i == STEP_W'(0)) |=> ((word_q & FLAG_MASK) == FLAG_MASK));  // R3

endmodule

// File: rtl/cls_port_drive.sv
// Module: cls_port_drive
// Forms the port level from the word in flight: the strobe bit is forced
// high on the middle level and low everywhere else; all other bits pass.
// Assumes: STROBE_BIT < WORD_W.
module cls_port_drive #(
    parameter int WORD_W     = 16,
    parameter int STROBE_BIT = 6
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              strobe_on_i,
    output logic [WORD_W-1:0] port_o
);

    localparam logic [WORD_W-1:0] STB_MASK = WORD_W'(1) << STROBE_BIT;

    // Override the strobe bit only
    always_comb begin
        port_o = (word_i & ~STB_MASK) | (strobe_on_i ? STB_MASK : '0);
    end

endmodule

// File: rtl/ctl_load_seq.sv
// Module: ctl_load_seq (top)
// Strobed control-word load sequencer. A start pulse plays a fixed script of
// three control transfers and four memory-sourced data transfers, each as a
// strobe-low, strobe-high, strobe-low triple, then pulses done.
// Assumes: memory returns data one cycle after rd_req_o; start is honoured
// only while idle.
module ctl_load_seq
    import ctl_load_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int HOLD_CYC   = 2,
    parameter int STROBE_BIT = 6,
    parameter int STOP_FLAG  = 14,
    parameter int CLEAR_FLAG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] ctl_word_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [WORD_W-1:0] port_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              done_o
);

    localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic [1:0]        level;
    logic [HOLD_W-1:0] hold;
    logic              accept;
    logic              advance;
    logic              fetch;
    logic              capture;
    logic [WORD_W-1:0] word;
    logic              strobe_on;

    cls_step_ctrl #(
        .HOLD_CYC (HOLD_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .state_o   (state),
        .step_o    (step),
        .level_o   (level),
        .hold_o    (hold),
        .accept_o  (accept),
        .advance_o (advance),
        .fetch_o   (fetch),
        .capture_o (capture),
        .done_o    (done_o)
    );

    cls_word_sel #(
        .WORD_W     (WORD_W),
        .ADDR_W     (ADDR_W),
        .STOP_FLAG  (STOP_FLAG),
        .CLEAR_FLAG (CLEAR_FLAG)
    ) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .advance_i   (advance),
        .capture_i   (capture),
        .step_i      (step),
        .ctl_word_i  (ctl_word_i),
        .base_addr_i (base_addr_i),
        .rd_data_i   (rd_data_i),
        .word_o      (word),
        .rd_addr_o   (rd_addr_o)
    );

    // Strobe high only on the middle level of a transfer
    assign strobe_on = (state == ST_XFER) && (level == 2'(STROBE_LVL));

    cls_port_drive #(
        .WORD_W     (WORD_W),
        .STROBE_BIT (STROBE_BIT)
    ) u_port (
        .word_i      (word),
        .strobe_on_i (strobe_on),
        .port_o      (port_o)
    );

    assign rd_req_o = fetch;

    AST_STROBE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        port_o[STROBE_BIT] |-> (state == ST_XFER));                        // R2
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> (!rd_req_o && !done_o));                              // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start_i) |=>
            !(state == ST_XFER && step == '0 && level == '0 && hold == '0));  // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (port_o == '0 && !rd_req_o && !done_o));                // R1

endmodule

// File: tb/ctl_load_seq_tb.sv
`timescale 1ns/1ps
module ctl_load_seq_tb;

    localparam int HOLD   = 2;
    localparam int ADDR_W = 8;
    localparam logic [15:0] STB   = 16'h0040;
    localparam logic [15:0] FLAGS = 16'h4400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [15:0]       ctl_word_i = '0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [15:0]       rd_data_i = '0;
    logic [15:0]       port_o;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              done_o;

    logic [15:0] mem [256];

    int checks = 0;
    int fails  = 0;

    // Expected per-cycle trace
    logic [15:0]       q_port [$];
    bit                q_req  [$];
    logic [ADDR_W-1:0] q_addr [$];
    bit                q_done [$];
    string             q_tag  [$];
    logic [15:0]       idle_port = '0;
    string             idle_tag  = "R1";

    always #5 clk = ~clk;

    ctl_load_seq #(.HOLD_CYC(HOLD)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ctl_word_i  (ctl_word_i),
        .base_addr_i (base_addr_i),
        .rd_data_i   (rd_data_i),
        .port_o      (port_o),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .done_o      (done_o)
    );

    // One-cycle-latency memory model
    always @(posedge clk) rd_data_i <= mem[rd_addr_o];

    task automatic push(input logic [15:0] p, input bit r, input logic [ADDR_W-1:0] a,
                        input bit d, input string t);
        q_port.push_back(p); q_req.push_back(r); q_addr.push_back(a);
        q_done.push_back(d); q_tag.push_back(t);
    endtask

    // Build the expected trace of one whole sequence
    task automatic plan_seq(input logic [15:0] ctl, input logic [ADDR_W-1:0] base);
        logic [15:0] w;
        logic [15:0] prev;
        string       t;
        prev = ctl;
        for (int s = 0; s < 7; s++) begin
            if (s >= 3) begin
                push(prev & ~STB, 1'b1, ADDR_W'(base + s - 3), 1'b0, "R5");
                push(prev & ~STB, 1'b0, '0, 1'b0, "R5");
                w = mem[ADDR_W'(base + s - 3)];
                t = "R4";
            end else if (s == 1) begin
                w = ctl | FLAGS;
                t = "R3";
            end else begin
                w = ctl;
                t = "R2";
            end
            for (int lv = 0; lv < 3; lv++)
                for (int h = 0; h < HOLD; h++)
                    push((lv == 1) ? (w | STB) : (w & ~STB), 1'b0, '0, 1'b0, t);
            prev = w;
        end
        push(prev & ~STB, 1'b0, '0, 1'b1, "R6");
        idle_port = prev & ~STB;
    endtask

    // Compare all outputs in the middle of each cycle
    task automatic tick();
        logic [15:0]       ep;
        bit                er;
        logic [ADDR_W-1:0] ea;
        bit                ed;
        string             et;
        @(negedge clk);
        if (q_port.size() > 0) begin
            ep = q_port.pop_front(); er = q_req.pop_front(); ea = q_addr.pop_front();
            ed = q_done.pop_front(); et = q_tag.pop_front();
        end else begin
            ep = idle_port; er = 1'b0; ea = '0; ed = 1'b0; et = idle_tag;
        end
        checks++;
        if (port_o !== ep || rd_req_o !== er || (er && rd_addr_o !== ea) || done_o !== ed) begin
            fails++;
            $display("FAIL %s: port=%h req=%b addr=%h done=%b expected port=%h req=%b addr=%h done=%b",
                     et, port_o, rd_req_o, rd_addr_o, done_o, ep, er, ea, ed);
        end
    endtask

    task automatic run_seq(input logic [15:0] ctl, input logic [ADDR_W-1:0] base);
        start_i = 1'b1; ctl_word_i = ctl; base_addr_i = base;
        plan_seq(ctl, base);
        tick();
        start_i = 1'b0;
        ctl_word_i = ~ctl; base_addr_i = ~base;   // R8: later input changes ignored
        while (q_port.size() > 0) tick();
        idle_tag = "R8";
        for (int i = 0; i < 3; i++) tick();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
        mem[8'hFF] = 16'hFFFF;
        mem[8'h00] = 16'h0040;
        mem[8'h20] = 16'h4400;

        // R1: reset state
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();

        run_seq(16'h0000, 8'h10);         // R3 flag insertion on zeros
        run_seq(16'h1234, 8'h20);         // R4 data with flag bits passes unchanged
        run_seq(16'hBFBF, 8'hFE);         // R5 address wrap, R4 strobe bit in data
        run_seq(16'h0041, 8'h40);         // R4 strobe bit of control word overridden

        // R7: start mid-sequence with new arguments
        start_i = 1'b1; ctl_word_i = 16'h2222; base_addr_i = 8'h50;
        plan_seq(16'h2222, 8'h50);
        tick();
        start_i = 1'b0;
        for (int i = 0; i < 12; i++) tick();
        start_i = 1'b1; ctl_word_i = 16'h0F0F; base_addr_i = 8'h90;
        tick();
        start_i = 1'b0;
        while (q_port.size() > 0) tick();
        // R7: start during the done cycle
        start_i = 1'b1; ctl_word_i = 16'h7777;
        idle_tag = "R7";
        tick();
        start_i = 1'b0;
        for (int i = 0; i < 10; i++) tick();

        run_seq(16'h4400, 8'h80);         // R3 flags already present

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule